// File: doc/BRIEF.md
# Scan-Burst Sample Decimator

This block sits in a sample stream between an acquisition FIFO and whatever consumes the samples. The converter behind the FIFO runs without pause at the conversion rate, but only one scan out of every group of consecutive scans is wanted. The block is programmed with a scan length and a delay count. It counts each incoming sample into a chunk of `scan length * (delay + 1)` samples. It forwards the first scan of every chunk and swallows the rest.

The delay count follows from the pacing the user asked for: `delay = scan_period / (conversion_period * scan_length) - 1`. A delay of zero gives plain pass-through. The position inside the chunk is held between arrivals, so samples can come in bursts of any size and with any gaps.

Both sides use a valid/ready handshake. Forwarded samples carry a flag on the first sample of each scan. The default output variant holds every forwarded sample in one register stage.

Top module: `scan_burst_decimator`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high. The configuration is scan length 1 and delay 0, so samples pass through until a new configuration is loaded.
- R2: Chunk length is `(cfg_scan_last + 1) * (cfg_delay + 1)`. Within each chunk the first `cfg_scan_last + 1` accepted samples are forwarded, in order and with unchanged data. The other samples of the chunk produce no output. After the last sample of a chunk the position returns to zero.
- R3: With a delay count of 0, every accepted sample appears at the output unchanged and in order.
- R4: The position inside the chunk is kept across idle cycles and input gaps of any length.
- R5: A sample at a discarded position is accepted (`in_ready` high) even while the output holds a sample that is not being taken.
- R6: A sample at a forwarded position is not accepted (`in_ready` low) while the output holds a sample and `out_ready` is low. The held `out_data` and `out_first` stay stable until taken.
- R7: In a cycle with `start` or `cfg_load` high, `in_ready` is low and the position is cleared. `cfg_load` also captures `cfg_scan_last` (scan length minus one) and `cfg_delay`. A sample already held at the output is kept and delivered.
- R8: `out_first` is high on the first forwarded sample of each scan (position 0 of a chunk) and low on the others.
- R9: In the registered output variant, a forwarded sample accepted at a clock edge is presented on `out_valid`/`out_data` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration fields and clear the position |
| cfg_scan_last | input | SCAN_IDX_W (4) | Scan length minus one |
| cfg_delay | input | DLY_W (8) | Number of discarded scans per chunk |
| start | input | 1 | Clear the position without changing the configuration |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | DATA_W (16) | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Sink takes the output sample |
| out_data | output | DATA_W (16) | Forwarded sample |
| out_first | output | 1 | Forwarded sample is the first of its scan |

## Verification
Two collisions matter most. The first is a restart (`start` or `cfg_load`) in the same cycle as an offered sample. The bench holds `in_valid` high through the control cycle and expects `in_ready` low there. It then expects the same sample to be accepted afterwards as position zero, with `out_first` set. The second is a discarded sample arriving while the output stage is stalled. The bench stops `out_ready` with a sample held, then checks that discard-position samples are still taken and a keep-position sample is refused. It also checks that the held value survives a configuration reload. Every output is compared against a reference position model in a scoreboard queue.

// File: rtl/scd_pkg.sv
package scd_pkg;

   typedef enum logic {
      SCD_OUT_PASS = 1'b0,
      SCD_OUT_REG  = 1'b1
   } out_mode_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/scd_pos_tracker.sv
module scd_pos_tracker #(
   parameter int unsigned SCAN_IDX_W = 4,
   parameter int unsigned DLY_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  advance,
   input  logic [SCAN_IDX_W-1:0] scan_last,
   input  logic [DLY_W-1:0]      delay,
   output logic                  keep,
   output logic                  first
);

   logic [SCAN_IDX_W-1:0] samp_q;
   logic [DLY_W-1:0]      scan_q;
   logic                  samp_wrap;
   logic                  scan_wrap;

   assign samp_wrap = (samp_q == scan_last);
   assign scan_wrap = (scan_q == delay);

   // position = scan_q * scan length + samp_q, kept as two counters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= '0;
         scan_q <= '0;
      end else if (clear) begin
         samp_q <= '0;
         scan_q <= '0;
      end else if (advance) begin
         if (samp_wrap) begin
            samp_q <= '0;
            scan_q <= scan_wrap ? '0 : scan_q + 1'b1;
         end else begin
            samp_q <= samp_q + 1'b1;
         end
      end
   end

   assign keep  = (scan_q == '0);
   assign first = keep && (samp_q == '0);

endmodule

// File: rtl/scd_out_stage.sv
module scd_out_stage #(
   parameter int unsigned       DATA_W   = 16,
   parameter scd_pkg::out_mode_e OUT_MODE = scd_pkg::SCD_OUT_REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_first,
   output logic              can_take,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_first
);

   generate
      if (OUT_MODE == scd_pkg::SCD_OUT_REG) begin : g_reg
         logic              ov_q;
         logic [DATA_W-1:0] od_q;
         logic              of_q;
         logic              take;

         assign can_take = !ov_q || out_ready;
         assign take     = push_valid && can_take;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ov_q <= 1'b0;
            end else if (take) begin
               ov_q <= 1'b1;
            end else if (out_ready) begin
               ov_q <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (take) begin
               od_q <= push_data;
               of_q <= push_first;
            end
         end

         assign out_valid = ov_q;
         assign out_data  = od_q;
         assign out_first = of_q;
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign can_take   = out_ready;
         assign out_valid  = push_valid;
         assign out_data   = push_data;
         assign out_first  = push_first;
      end
   endgenerate

endmodule

// File: rtl/scan_burst_decimator.sv
module scan_burst_decimator #(
   parameter int unsigned        DATA_W     = 16,
   parameter int unsigned        SCAN_MAX   = 16,
   parameter int unsigned        DELAY_MAX  = 255,
   parameter scd_pkg::out_mode_e OUT_MODE   = scd_pkg::SCD_OUT_REG,
   localparam int unsigned       SCAN_IDX_W = scd_pkg::idx_width(SCAN_MAX),
   localparam int unsigned       DLY_W      = scd_pkg::idx_width(DELAY_MAX + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_load,
   input  logic [SCAN_IDX_W-1:0] cfg_scan_last,
   input  logic [DLY_W-1:0]      cfg_delay,
   input  logic                  start,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [DATA_W-1:0]     in_data,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [DATA_W-1:0]     out_data,
   output logic                  out_first
);

   initial begin
      if (DATA_W < 1)   $error("DATA_W must be at least 1");
      if (SCAN_MAX < 1) $error("SCAN_MAX must be at least 1");
   end

   logic [SCAN_IDX_W-1:0] scan_last_q;
   logic [DLY_W-1:0]      delay_q;
   logic                  ctrl;
   logic                  keep_w;
   logic                  first_w;
   logic                  can_take_w;
   logic                  accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_last_q <= '0;
         delay_q     <= '0;
      end else if (cfg_load) begin
         scan_last_q <= cfg_scan_last;
         delay_q     <= cfg_delay;
      end
   end

   assign ctrl     = start || cfg_load;
   assign in_ready = !ctrl && (!keep_w || can_take_w);
   assign accept   = in_valid && in_ready;

   scd_pos_tracker #(
      .SCAN_IDX_W(SCAN_IDX_W),
      .DLY_W     (DLY_W)
   ) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ctrl),
      .advance  (accept),
      .scan_last(scan_last_q),
      .delay    (delay_q),
      .keep     (keep_w),
      .first    (first_w)
   );

   scd_out_stage #(
      .DATA_W  (DATA_W),
      .OUT_MODE(OUT_MODE)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_valid(in_valid && keep_w && !ctrl),
      .push_data (in_data),
      .push_first(first_w),
      .can_take  (can_take_w),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_first (out_first)
   );

endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
   parameter int unsigned DATA_W  = 16,
   parameter bit          REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              keep,
   input logic              dly_zero,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_first
);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_OUT && out_valid && !out_ready) |=>
         (out_valid && $stable(out_data) && $stable(out_first)));

   // R7
   ctrl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl |-> !in_ready);

   // R3
   pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_OUT && dly_zero && in_valid && in_ready) |=> out_valid);

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_OUT && in_valid && in_ready && keep) |=>
         (out_valid && out_data == $past(in_data)));

   // R2
   drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_OUT && in_valid && in_ready && !keep && !out_valid) |=> !out_valid);

   // R5
   drop_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !keep && !ctrl) |-> in_ready);

endmodule

bind scan_burst_decimator scd_checker #(
   .DATA_W (DATA_W),
   .REG_OUT(OUT_MODE == scd_pkg::SCD_OUT_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl     (start || cfg_load),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_data  (in_data),
   .keep     (keep_w),
   .dly_zero (delay_q == '0),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .out_first(out_first)
);

// File: tb/sim_scan_burst_decimator.sv
module sim_scan_burst_decimator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [3:0]  cfg_scan_last = '0;
   logic [7:0]  cfg_delay = '0;
   logic        start = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_data;
   logic        out_first;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string tag = "R1";

   logic [16:0] exp_q[$];
   int m_samp = 0, m_scan = 0, m_last = 0, m_dly = 0;
   bit lat_pend = 1'b0;
   logic [15:0] lat_d = '0;

   always #5 clk = ~clk;

   scan_burst_decimator u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_scan_last(cfg_scan_last),
      .cfg_delay(cfg_delay), .start(start), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_first(out_first)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model and scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (lat_pend) begin
            chk(out_valid && out_data == lat_d, "R9 one-cycle latency", int'(out_data), int'(lat_d));
            lat_pend = 1'b0;
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected output", int'(out_data), -1);
            end else begin
               logic [16:0] e;
               e = exp_q.pop_front();
               chk(out_data == e[15:0], tag, int'(out_data), int'(e[15:0]));
               chk(out_first == e[16], "R8 first flag", int'(out_first), int'(e[16]));
            end
         end
         if (start || cfg_load) begin
            if (in_valid) chk(!in_ready, "R7 input blocked in control cycle", int'(in_ready), 0);
            if (cfg_load) begin
               m_last = int'(cfg_scan_last);
               m_dly  = int'(cfg_delay);
            end
            m_samp = 0;
            m_scan = 0;
         end else if (in_valid && in_ready) begin
            if (m_scan == 0) begin
               exp_q.push_back({(m_samp == 0), in_data});
               if (!out_valid || out_ready) begin
                  lat_pend = 1'b1;
                  lat_d = in_data;
               end
            end
            if (m_samp == m_last) begin
               m_samp = 0;
               m_scan = (m_scan == m_dly) ? 0 : m_scan + 1;
            end else begin
               m_samp++;
            end
         end
      end
   end

   task automatic aligned();
      @(posedge clk); #1;
   endtask

   task automatic send(input logic [15:0] d);
      in_valid = 1'b1;
      in_data  = d;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic load_cfg(input int last, input int dly);
      cfg_load = 1'b1;
      cfg_scan_last = last[3:0];
      cfg_delay = dly[7:0];
      aligned();
      cfg_load = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) aligned();
      chk(exp_q.size() == 0, "R2 all expected outputs delivered", exp_q.size(), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      #12;
      // R1: reset state
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      #20;
      rst_n = 1'b1;
      aligned();
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
      aligned();

      // R1/R3: default configuration passes everything
      tag = "R1 default pass-through";
      for (int i = 0; i < 6; i++) send(16'h1000 + 16'(i));
      drain();

      tag = "R3 delay zero pass-through";
      load_cfg(2, 0);
      for (int i = 0; i < 9; i++) send(16'h2000 + 16'(i * 7));
      drain();

      // R2: scan length 3, delay 2 -> chunk 9, keep first 3
      tag = "R2 keep leading scan";
      load_cfg(2, 2);
      for (int i = 0; i < 30; i++) send(16'h3000 + 16'(i));
      drain();

      // R4/R6: gaps of varying length with a stalling sink
      tag = "R4 position across gaps";
      load_cfg(3, 1);
      fork
         begin
            for (int i = 0; i < 40; i++) begin
               send(16'h4000 + 16'(i * 3));
               for (int g = 0; g < (i % 4) * 3; g++) aligned();
            end
         end
         begin
            for (int k = 0; k < 300; k++) begin
               out_ready = (k % 3) != 0;
               aligned();
            end
            out_ready = 1'b1;
         end
      join
      drain();

      // R5/R6/R7: stalled output
      tag = "R6 held sample";
      load_cfg(0, 3);
      out_ready = 1'b0;
      send(16'h5A00);
      in_valid = 1'b1; in_data = 16'h5A01;
      @(negedge clk);
      chk(in_ready == 1'b1, "R5 discard accepted while stalled", int'(in_ready), 1);
      chk(out_valid && out_data == 16'h5A00, "R6 output held", int'(out_data), 16'h5A00);
      aligned(); in_data = 16'h5A02;
      aligned(); in_data = 16'h5A03;
      aligned(); in_data = 16'h5A04;
      @(negedge clk);
      chk(in_ready == 1'b0, "R6 keep refused while stalled", int'(in_ready), 0);
      chk(out_valid && out_data == 16'h5A00 && out_first, "R6 output stable", int'(out_data), 16'h5A00);
      aligned();
      in_valid = 1'b0;
      load_cfg(1, 0);
      @(negedge clk);
      chk(out_valid && out_data == 16'h5A00, "R7 pending output kept over reload", int'(out_data), 16'h5A00);
      aligned();
      out_ready = 1'b1;
      drain();

      // R7: start collides with an offered sample
      tag = "R7 restart";
      load_cfg(1, 1);
      send(16'h6000);
      in_valid = 1'b1; in_data = 16'h6001; start = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 start blocks input", int'(in_ready), 0);
      aligned();
      start = 1'b0;
      send(16'h6001);
      for (int i = 2; i < 10; i++) send(16'h6000 + 16'(i));
      drain();

      // R8: first flag across several chunks with delay 0, scan length 4
      tag = "R8 scan framing";
      load_cfg(3, 0);
      for (int i = 0; i < 12; i++) send(16'h7000 + 16'(i));
      drain();

      finish_run();
   end

endmodule